// File: doc/BRIEF.md
# Converter Soft-Start Sequencer

This block takes a boost converter from idle to regulated operation. It advances only on a periodic tick strobe, a one-cycle pulse from a slower scheduler. It does not compute duty cycles and it does not run the compensation filter. It tells the filter and the PWM when to run, which reference to track, when to drop their history and when to preload a precharge duty that is supplied from outside.

The sequence has eight states, with the 3-bit codes below.

| State | Code | Behaviour |
|---|---|---|
| idle | 0 | Everything is off and the reference is zero. |
| power-on delay | 1 | A fixed wait while the inputs settle. |
| charge wait | 2 | Waits for the output to charge up through the rectifier path. A timeout ends it. |
| preload | 3 | Issues a one-cycle strobe to precharge the loop. The reference is seeded from the residual output. |
| ramp | 4 | Steps the reference up to the nominal value with PWM and loop running. |
| power-good wait | 5 | Qualifies the output as steady. |
| online | 6 | Regulates and slews the reference toward any new command. |
| suspend | 7 | Turns everything off, strobes a history clear and goes back to idle. |

The transitions are named as follows:
- start: idle to power-on delay.
- settle-done: power-on delay to charge wait, or to preload when the charge time is zero.
- charged: charge wait to preload.
- charge-timeout: charge wait to idle.
- early-abort: power-on delay, charge wait or preload to idle.
- launch: preload to ramp.
- ramp-done: ramp to power-good wait.
- qualified: power-good wait to online.
- trip: ramp, power-good wait or online to suspend.
- recover: suspend to idle.

The power-good pin is built in one of two variants, chosen by a parameter. In push-pull form it always drives its level. In open-drain form it pulls low while the converter is not good and releases the line when it is good.

Top module: `boost_softstart_seq`

## Requirements
- R1: Out of reset the state is idle (code 0), with pwm_en and loop_en low, vref zero and the power-good pin reporting not-good. pwm_en and loop_en are never high in idle.
- R2: The start transition fires on a tick only when these all hold: enable is high, go is high or auto_run is high, fault is low and shutdown is low. Without enable the machine stays idle.
- R3: The power-on delay lasts PON_TICKS ticks, and on the last of them settle-done fires. A fault or a shutdown on any tick of this delay returns the machine to idle.
- R4: Count the ticks spent in charge wait, including the current one. The charged transition fires on the first tick where that count is at least CHG_MIN_TICKS and vout is at least vin minus DIODE_DROP. If the count reaches CHG_TIMEOUT_TICKS before that, the machine returns to idle. With CHG_MIN_TICKS equal to 0 the machine skips charge wait and goes straight to preload.
- R5: On entering preload, pre_load is high for exactly one clock and init_duty captures pre_duty. vref is loaded with the smaller of vout and vref_nom, and pwm_en stays low.
- R6: In ramp, pwm_en and loop_en are high and vref moves toward vref_nom by REF_STEP on each tick, landing exactly on the target in its last step. The machine enters power-good wait on the tick where vref reaches vref_nom.
- R7: Power-good wait reaches online after PG_TICKS consecutive ticks in which the magnitude of vout minus vref is at most PG_BAND. A tick with a larger deviation restarts the count. The PG_MAX_GLITCH-th such restart goes to suspend instead.
- R8: The power-good pin reports good in online, and only there.
- R9: In online, vref follows changes in vref_nom by at most REF_STEP per tick, never by jumping.
- R10: A fault or shutdown on a tick in ramp, power-good wait or online enters suspend. On entry pwm_en and loop_en drop and hist_clr is high for exactly one clock. The next tick returns the machine to idle with vref zero.
- R11: With PG_OPEN_DRAIN equal to 0 the pin is push-pull: pg_oe is 1 and pg_dat equals good. With PG_OPEN_DRAIN equal to 1 the pin is open-drain: pg_dat is 0 and pg_oe is the inverse of good.
- R12: The state and vref change only on clocks where tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse that advances the sequencer |
| enable | input | 1 | External enable request |
| go | input | 1 | Start permission |
| auto_run | input | 1 | Treat go as set whenever enable is set |
| fault | input | 1 | Any fault currently active |
| shutdown | input | 1 | Shutdown command |
| vout | input | VW | Measured output voltage code |
| vin | input | VW | Measured input voltage code |
| vref_nom | input | VW | Commanded nominal reference |
| pre_duty | input | DW | Externally estimated precharge duty |
| pwm_en | output | 1 | PWM outputs enabled |
| loop_en | output | 1 | Control loop enabled |
| vref | output | VW | Reference handed to the loop |
| hist_clr | output | 1 | One-cycle loop history clear strobe |
| pre_load | output | 1 | One-cycle loop precharge strobe |
| init_duty | output | DW | Duty captured at precharge |
| pg_dat | output | 1 | Power-good pin data |
| pg_oe | output | 1 | Power-good pin drive enable |
| state | output | 3 | Current state code |

## Verification
The bench targets the edges of each counted window. These are the last tick of the power-on delay, the tick where charge wait times out, and the tick where the charge is reached exactly at the minimum time. A design that is off by one in any of them leaves its state a tick early or late, and the bench reports the wrong state code on that tick. In power-good wait the bench applies a deviation exactly equal to the band and one just past it. It then counts exactly PG_TICKS clean ticks after a glitch. A comparator that is off by one, or a timer that fails to restart, reaches online at the wrong tick. The bench also applies repeated glitches to catch a design that never forces suspend. Ramp and online slewing are compared tick by tick against a stepped model, including final steps smaller than REF_STEP and random retargets in both directions. A design that overshoots or jumps fails on the first tick where it does so. A second instance with zero charge time and an open-drain pin checks the skip of charge wait and the inverted drive.

// File: rtl/sss_pkg.sv
package sss_pkg;
    typedef enum logic [2:0] {
        SS_IDLE    = 3'd0,
        SS_PON     = 3'd1,
        SS_CHARGE  = 3'd2,
        SS_PRELOAD = 3'd3,
        SS_RAMP    = 3'd4,
        SS_PGWAIT  = 3'd5,
        SS_ONLINE  = 3'd6,
        SS_SUSPEND = 3'd7
    } sss_state_e;
endpackage

// File: rtl/sss_tick_counter.sv
module sss_tick_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sss_ref_slewer.sv
module sss_ref_slewer #(
    parameter int VW       = 12,
    parameter int REF_STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [VW-1:0] load_val,
    input  logic          step,
    input  logic [VW-1:0] target,
    output logic [VW-1:0] ref_q,
    output logic [VW-1:0] step_nxt
);
    localparam logic [VW-1:0] STEP_V = VW'(REF_STEP);

    logic [VW-1:0] ref_d;

    // value one step closer to target, saturating on it
    always_comb begin
        if (ref_q < target) begin
            step_nxt = ((target - ref_q) > STEP_V) ? ref_q + STEP_V : target;
        end else if (ref_q > target) begin
            step_nxt = ((ref_q - target) > STEP_V) ? ref_q - STEP_V : target;
        end else begin
            step_nxt = ref_q;
        end
    end

    always_comb begin
        ref_d = ref_q;
        if (clr) begin
            ref_d = '0;
        end else if (load) begin
            ref_d = load_val;
        end else if (step) begin
            ref_d = step_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else begin
            ref_q <= ref_d;
        end
    end
endmodule

// File: rtl/sss_pg_pin.sv
module sss_pg_pin #(
    parameter int OPEN_DRAIN = 0
) (
    input  logic good,
    output logic pin_dat,
    output logic pin_oe
);
    generate
        if (OPEN_DRAIN != 0) begin : g_open_drain
            assign pin_dat = 1'b0;
            assign pin_oe  = !good;
        end else begin : g_push_pull
            assign pin_dat = good;
            assign pin_oe  = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/boost_softstart_seq.sv
module boost_softstart_seq
    import sss_pkg::*;
#(
    parameter int VW                = 12,
    parameter int DW                = 10,
    parameter int CW                = 16,
    parameter int PON_TICKS         = 20,
    parameter int CHG_MIN_TICKS     = 5,
    parameter int CHG_TIMEOUT_TICKS = 40,
    parameter int PG_TICKS          = 16,
    parameter int PG_MAX_GLITCH     = 3,
    parameter int REF_STEP          = 8,
    parameter int DIODE_DROP        = 20,
    parameter int PG_BAND           = 24,
    parameter int PG_OPEN_DRAIN     = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          enable,
    input  logic          go,
    input  logic          auto_run,
    input  logic          fault,
    input  logic          shutdown,
    input  logic [VW-1:0] vout,
    input  logic [VW-1:0] vin,
    input  logic [VW-1:0] vref_nom,
    input  logic [DW-1:0] pre_duty,
    output logic          pwm_en,
    output logic          loop_en,
    output logic [VW-1:0] vref,
    output logic          hist_clr,
    output logic          pre_load,
    output logic [DW-1:0] init_duty,
    output logic          pg_dat,
    output logic          pg_oe,
    output logic [2:0]    state
);
    localparam int RCW = $clog2(PG_MAX_GLITCH + 1);
    localparam logic [CW:0]   PON_LIM  = (CW+1)'(PON_TICKS);
    localparam logic [CW:0]   CHG_LIM  = (CW+1)'(CHG_MIN_TICKS);
    localparam logic [CW:0]   TMO_LIM  = (CW+1)'(CHG_TIMEOUT_TICKS);
    localparam logic [CW:0]   PG_LIM   = (CW+1)'(PG_TICKS);
    localparam logic [RCW:0]  GL_LIM   = (RCW+1)'(PG_MAX_GLITCH);
    localparam logic [VW-1:0] DROP_V   = VW'(DIODE_DROP);
    localparam logic [VW-1:0] BAND_V   = VW'(PG_BAND);

    sss_state_e st_q, st_d;

    logic          go_eff, abort_req, vout_charged, glitch;
    logic [VW-1:0] chg_target, deviation, seed_val, step_nxt;
    logic [CW-1:0] tmr_cnt;
    logic [CW:0]   tmr_n;
    logic [RCW-1:0] gl_cnt;
    logic [RCW:0]  gl_n;
    logic          tmr_clr, tmr_inc, gl_clr, gl_inc;
    logic          ref_clr, ref_load, ref_step;
    logic          pg_good;
    logic          pre_load_q, hist_clr_q;
    logic [DW-1:0] init_duty_q;

    assign go_eff       = go | (auto_run & enable);
    assign abort_req    = fault | shutdown;
    assign chg_target   = (vin > DROP_V) ? (vin - DROP_V) : '0;
    assign vout_charged = (vout >= chg_target);
    assign deviation    = (vout > vref) ? (vout - vref) : (vref - vout);
    assign glitch       = (deviation > BAND_V);
    assign seed_val     = (vout < vref_nom) ? vout : vref_nom;
    assign tmr_n        = {1'b0, tmr_cnt} + 1'b1;
    assign gl_n         = {1'b0, gl_cnt} + 1'b1;

    sss_tick_counter #(.W(CW)) u_phase_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .count (tmr_cnt)
    );

    sss_tick_counter #(.W(RCW)) u_glitch_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gl_clr),
        .inc   (gl_inc),
        .count (gl_cnt)
    );

    sss_ref_slewer #(.VW(VW), .REF_STEP(REF_STEP)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ref_clr),
        .load     (ref_load),
        .load_val (seed_val),
        .step     (ref_step),
        .target   (vref_nom),
        .ref_q    (vref),
        .step_nxt (step_nxt)
    );

    // next state and datapath controls, evaluated on tick only
    always_comb begin
        st_d     = st_q;
        tmr_clr  = 1'b0;
        tmr_inc  = 1'b0;
        gl_clr   = 1'b0;
        gl_inc   = 1'b0;
        ref_clr  = 1'b0;
        ref_load = 1'b0;
        ref_step = 1'b0;
        if (tick) begin
            unique case (st_q)
                SS_IDLE: begin
                    if (enable && go_eff && !abort_req) st_d = SS_PON;
                end
                SS_PON: begin
                    if (abort_req) begin
                        st_d = SS_IDLE;
                    end else if (tmr_n >= PON_LIM) begin
                        st_d = (CHG_MIN_TICKS == 0) ? SS_PRELOAD : SS_CHARGE;
                    end
                end
                SS_CHARGE: begin
                    if (abort_req) begin
                        st_d = SS_IDLE;
                    end else if (vout_charged && (tmr_n >= CHG_LIM)) begin
                        st_d = SS_PRELOAD;
                    end else if (tmr_n >= TMO_LIM) begin
                        st_d = SS_IDLE;
                    end
                end
                SS_PRELOAD: begin
                    if (abort_req) begin
                        st_d    = SS_IDLE;
                        ref_clr = 1'b1;
                    end else begin
                        st_d = SS_RAMP;
                    end
                end
                SS_RAMP: begin
                    if (abort_req) begin
                        st_d = SS_SUSPEND;
                    end else begin
                        ref_step = 1'b1;
                        if (step_nxt == vref_nom) st_d = SS_PGWAIT;
                    end
                end
                SS_PGWAIT: begin
                    if (abort_req) begin
                        st_d = SS_SUSPEND;
                    end else if (glitch) begin
                        if (gl_n >= GL_LIM) begin
                            st_d = SS_SUSPEND;
                        end else begin
                            tmr_clr = 1'b1;
                            gl_inc  = 1'b1;
                        end
                    end else if (tmr_n >= PG_LIM) begin
                        st_d = SS_ONLINE;
                    end
                end
                SS_ONLINE: begin
                    if (abort_req) begin
                        st_d = SS_SUSPEND;
                    end else begin
                        ref_step = 1'b1;
                    end
                end
                SS_SUSPEND: begin
                    st_d    = SS_IDLE;
                    ref_clr = 1'b1;
                end
            endcase

            if (st_d != st_q) begin
                tmr_clr = 1'b1;
            end else if (!tmr_clr) begin
                tmr_inc = 1'b1;
            end
            if ((st_d == SS_PGWAIT) && (st_q != SS_PGWAIT)) gl_clr = 1'b1;
            if ((st_d == SS_PRELOAD) && (st_q != SS_PRELOAD)) ref_load = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs: levels decoded from state, strobes registered on entry
    always_comb begin
        pwm_en  = 1'b0;
        loop_en = 1'b0;
        pg_good = 1'b0;
        unique case (st_q)
            SS_RAMP, SS_PGWAIT: begin
                pwm_en  = 1'b1;
                loop_en = 1'b1;
            end
            SS_ONLINE: begin
                pwm_en  = 1'b1;
                loop_en = 1'b1;
                pg_good = 1'b1;
            end
            SS_IDLE, SS_PON, SS_CHARGE, SS_PRELOAD, SS_SUSPEND: begin
                pwm_en  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_load_q  <= 1'b0;
            hist_clr_q  <= 1'b0;
            init_duty_q <= '0;
        end else begin
            pre_load_q <= ref_load;
            hist_clr_q <= tick && (st_d == SS_SUSPEND) && (st_q != SS_SUSPEND);
            if (ref_load) init_duty_q <= pre_duty;
        end
    end

    sss_pg_pin #(.OPEN_DRAIN(PG_OPEN_DRAIN)) u_pg_pin (
        .good    (pg_good),
        .pin_dat (pg_dat),
        .pin_oe  (pg_oe)
    );

    assign pre_load  = pre_load_q;
    assign hist_clr  = hist_clr_q;
    assign init_duty = init_duty_q;
    assign state     = st_q;
endmodule

// File: rtl/sss_checker.sv
module sss_checker
    import sss_pkg::*;
#(
    parameter int VW            = 12,
    parameter int REF_STEP      = 8,
    parameter int PG_OPEN_DRAIN = 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          enable,
    input logic          fault,
    input logic          pwm_en,
    input logic          loop_en,
    input logic [VW-1:0] vref,
    input logic          hist_clr,
    input logic          pre_load,
    input logic          pg_dat,
    input logic          pg_oe,
    input logic [2:0]    state
);
    localparam logic [VW-1:0] STEP_V = VW'(REF_STEP);

    logic pg_seen;
    assign pg_seen = (PG_OPEN_DRAIN != 0) ? !pg_oe : pg_dat;

    function automatic logic [VW-1:0] adiff(input logic [VW-1:0] a, input logic [VW-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    assert_idle_outputs_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SS_IDLE) |-> (!pwm_en && !loop_en));

    assert_no_start_without_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (state == SS_IDLE) && !enable) |=> (state == SS_IDLE));

    assert_pon_fault_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (state == SS_PON) && fault) |=> (state == SS_IDLE));

    assert_preload_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_load |-> ((state == SS_PRELOAD) && !loop_en));

    assert_ref_slew_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ((state == SS_RAMP) || (state == SS_ONLINE))) |=> (adiff(vref, $past(vref)) <= STEP_V));

    assert_pg_only_online_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pg_seen |-> (state == SS_ONLINE));

    assert_hist_clr_in_suspend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hist_clr |-> ((state == SS_SUSPEND) && !pwm_en));

    assert_suspend_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (state == SS_SUSPEND)) |=> (state == SS_IDLE));

    assert_tick_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(state) && $stable(vref)));
endmodule

bind boost_softstart_seq sss_checker #(
    .VW            (VW),
    .REF_STEP      (REF_STEP),
    .PG_OPEN_DRAIN (PG_OPEN_DRAIN)
) u_sss_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .enable   (enable),
    .fault    (fault),
    .pwm_en   (pwm_en),
    .loop_en  (loop_en),
    .vref     (vref),
    .hist_clr (hist_clr),
    .pre_load (pre_load),
    .pg_dat   (pg_dat),
    .pg_oe    (pg_oe),
    .state    (state)
);

// File: tb/tb_boost_softstart_seq.sv
module tb_boost_softstart_seq;
    localparam int CLK_PERIOD = 10;
    localparam int STEP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, en_a = 1'b0, en_b = 1'b0, go = 1'b0, auto_run = 1'b0;
    logic fault = 1'b0, shutdown = 1'b0;
    logic [11:0] vout = '0, vin = '0, nom = '0;
    logic [9:0]  duty = '0;

    logic pwm_a, loop_a, hclr_a, pld_a, pgd_a, pgo_a;
    logic [11:0] vref_a;
    logic [9:0]  idut_a;
    logic [2:0]  st_a;
    logic pwm_b, loop_b, hclr_b, pld_b, pgd_b, pgo_b;
    logic [11:0] vref_b;
    logic [9:0]  idut_b;
    logic [2:0]  st_b;

    int checks = 0;
    int errors = 0;
    int exp_ref;

    always #(CLK_PERIOD/2) clk = ~clk;

    boost_softstart_seq dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(en_a), .go(go), .auto_run(auto_run),
        .fault(fault), .shutdown(shutdown), .vout(vout), .vin(vin), .vref_nom(nom),
        .pre_duty(duty), .pwm_en(pwm_a), .loop_en(loop_a), .vref(vref_a), .hist_clr(hclr_a),
        .pre_load(pld_a), .init_duty(idut_a), .pg_dat(pgd_a), .pg_oe(pgo_a), .state(st_a)
    );

    boost_softstart_seq #(.CHG_MIN_TICKS(0), .PG_OPEN_DRAIN(1)) dut_b (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(en_b), .go(go), .auto_run(auto_run),
        .fault(fault), .shutdown(shutdown), .vout(vout), .vin(vin), .vref_nom(nom),
        .pre_duty(duty), .pwm_en(pwm_b), .loop_en(loop_b), .vref(vref_b), .hist_clr(hclr_b),
        .pre_load(pld_b), .init_duty(idut_b), .pg_dat(pgd_b), .pg_oe(pgo_b), .state(st_b)
    );

    function automatic int slew(input int cur, input int tgt);
        if (cur < tgt) return ((tgt - cur) > STEP) ? cur + STEP : tgt;
        if (cur > tgt) return ((cur - tgt) > STEP) ? cur - STEP : tgt;
        return cur;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, both pin variants (R11)
        check("R1 state", st_a, 0);
        check("R1 pwm", pwm_a, 0);
        check("R1 loop", loop_a, 0);
        check("R1 vref", vref_a, 0);
        check("R11 pp dat", pgd_a, 0);
        check("R11 pp oe", pgo_a, 1);
        check("R11 od oe", pgo_b, 1);
        check("R11 od dat", pgd_b, 0);

        // R2 start qualification
        en_a = 1'b1; vin = 12'd1000; vout = 12'd900; nom = 12'd1500; duty = 10'h2A5;
        ticks(3);
        check("R2 no go", st_a, 0);
        go = 1'b1; fault = 1'b1;
        do_tick();
        check("R2 fault blocks", st_a, 0);
        fault = 1'b0; go = 1'b0; auto_run = 1'b1;
        do_tick();
        check("R2 autorun start", st_a, 1);

        // R12 no progress without tick
        repeat (6) @(negedge clk);
        check("R12 hold", st_a, 1);

        // R3 fault abort then full delay
        ticks(10);
        fault = 1'b1;
        do_tick();
        check("R3 fault abort", st_a, 0);
        fault = 1'b0;
        do_tick();
        check("R3 restart", st_a, 1);
        ticks(19);
        check("R3 before end", st_a, 1);
        do_tick();
        check("R3 end", st_a, 2);

        // R4 timeout, then charged at minimum time
        ticks(39);
        check("R4 before timeout", st_a, 2);
        do_tick();
        check("R4 timeout", st_a, 0);
        do_tick();
        ticks(20);
        check("R4 back in charge", st_a, 2);
        vout = 12'd980;
        ticks(4);
        check("R4 before min", st_a, 2);
        vout = 12'd990;
        do_tick();
        check("R4 charged", st_a, 3);

        // R5 precharge
        check("R5 strobe", pld_a, 1);
        check("R5 duty", idut_a, 10'h2A5);
        check("R5 seed", vref_a, 990);
        check("R5 pwm off", pwm_a, 0);
        @(negedge clk);
        check("R5 strobe width", pld_a, 0);

        // R6 ramp
        do_tick();
        check("R6 ramp state", st_a, 4);
        check("R6 pwm", pwm_a, 1);
        check("R6 loop", loop_a, 1);
        check("R6 first ref", vref_a, 990);
        vout = 12'd1500;
        exp_ref = 990;
        for (int i = 1; i <= 64; i++) begin
            do_tick();
            exp_ref = slew(exp_ref, 1500);
            check("R6 ref step", vref_a, exp_ref);
            check("R6 ramp end", st_a, (i < 64) ? 4 : 5);
        end

        // R7 power-good window with boundary and glitch
        for (int i = 1; i <= 10; i++) begin
            vout = (i == 5) ? 12'd1524 : 12'd1500;
            do_tick();
        end
        check("R7 band edge ok", st_a, 5);
        vout = 12'd1525;
        do_tick();
        vout = 12'd1500;
        check("R7 glitch stays", st_a, 5);
        ticks(15);
        check("R7 timer restarted", st_a, 5);
        check("R8 not yet good", pgd_a, 0);
        do_tick();
        check("R7 qualified", st_a, 6);
        check("R8 good", pgd_a, 1);
        check("R11 pp oe online", pgo_a, 1);

        // R9 online slewing, directed then random
        nom = 12'd1600;
        do_tick();
        check("R9 up step", vref_a, 1508);
        exp_ref = 1508;
        for (int k = 0; k < 30; k++) begin
            nom = 12'(($urandom % 3900) + 100);
            for (int j = 0; j < 6; j++) begin
                do_tick();
                exp_ref = slew(exp_ref, int'(nom));
                check("R9 slew", vref_a, exp_ref);
            end
        end
        check("R9 still online", st_a, 6);

        // R10 shutdown
        shutdown = 1'b1;
        do_tick();
        check("R10 suspend", st_a, 7);
        check("R10 hist clr", hclr_a, 1);
        check("R10 pwm off", pwm_a, 0);
        check("R8 pg dropped", pgd_a, 0);
        @(negedge clk);
        check("R10 hist clr width", hclr_a, 0);
        shutdown = 1'b0;
        do_tick();
        check("R10 back idle", st_a, 0);
        check("R10 ref zero", vref_a, 0);

        // R7 repeated glitches force suspend
        nom = 12'd1500; vout = 12'd1500;
        do_tick();
        ticks(20);
        ticks(5);
        check("R4 charged again", st_a, 3);
        check("R5 seed clamp", vref_a, 1500);
        do_tick();
        do_tick();
        check("R6 zero-length ramp", st_a, 5);
        vout = 12'd1600;
        ticks(2);
        check("R7 two glitches", st_a, 5);
        do_tick();
        check("R7 glitch limit", st_a, 7);
        vout = 12'd1500;
        do_tick();
        check("R10 recover", st_a, 0);

        // R10 fault during ramp
        nom = 12'd1700;
        do_tick();
        ticks(25);
        do_tick();
        do_tick();
        check("R6 ramping", st_a, 4);
        check("R6 ramp ref", vref_a, 1508);
        fault = 1'b1;
        do_tick();
        check("R10 fault trip", st_a, 7);
        check("R10 loop off", loop_a, 0);
        fault = 1'b0; en_a = 1'b0;
        do_tick();
        do_tick();
        check("R2 no enable idle", st_a, 0);

        // second instance: charge skip and open-drain pin
        en_b = 1'b1; vout = 12'd300; nom = 12'd500;
        do_tick();
        check("R2 b start", st_b, 1);
        ticks(19);
        check("R3 b delay", st_b, 1);
        do_tick();
        check("R4 skip charge", st_b, 3);
        check("R5 b seed", vref_b, 300);
        do_tick();
        ticks(24);
        check("R6 b ramp", st_b, 4);
        do_tick();
        check("R6 b ramp done", st_b, 5);
        vout = 12'd500;
        ticks(16);
        check("R8 b online", st_b, 6);
        check("R11 od released", pgo_b, 0);
        check("R11 od dat", pgd_b, 0);
        check("R2 a stays idle", st_a, 0);
        shutdown = 1'b1;
        do_tick();
        check("R10 b suspend", st_b, 7);
        check("R11 od pulls low", pgo_b, 1);
        shutdown = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule